// File: doc/BRIEF.md
# Sticky Multi-Bit Value Capture Register

This block is a register of configurable width (8 bits by default) that records a hardware status word. While the register holds zero, it loads the first nonzero word it samples on its hardware input. From then on it keeps that word and ignores every later input value, whether or not the input changes, until software writes the register.

The capture acts on the whole word, not bit by bit. A single event is kept intact, and later activity cannot merge into it. Software reads the held word, then writes zero to re-arm the register. A software write always takes priority over a hardware capture in the same cycle. A nonzero write loads the written value, and that value also blocks capture until the register is zeroed again.

Top module: `sticky_cap_reg`

## Requirements
- R1: After a synchronous reset, and while reset is held, the read data is 0, whatever the hardware input is.
- R2: When the stored value is 0, software is not writing and the hardware input is nonzero, the input word is stored at that clock edge. It is visible on the read data right after that edge.
- R3: When the stored value is nonzero and software is not writing, the stored value does not change, even if the input is nonzero and different.
- R4: When the stored value is 0, the input is 0 and software is not writing, the stored value stays 0.
- R5: A software write of 0 clears the register. If the input is still nonzero on the next clock, that same word is captured again.
- R6: In a cycle with both a software write and a possible hardware capture, the written value is stored. Capture can resume on the following clock.
- R7: A software write of a nonzero value stores that value. Nonzero inputs are then ignored until the register is next set to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hw_value | input | WIDTH | Hardware word offered for capture |
| wr_en | input | 1 | Software write strobe, one cycle per write |
| wr_data | input | WIDTH | Software write data |
| rd_data | output | WIDTH | Current stored value, for software reads |

## Verification
The hardest case to reach is a clearing write in the same cycle as a nonzero input. It is followed by the re-capture of that still-present input one cycle later. The vector walk holds the input nonzero across the write and the cycle after it. It checks that the write wins first, and that the same word is then captured again. A second case uses a write of zero while a new nonzero word arrives. A third uses a nonzero software write followed by nonzero inputs, to show that capture stays blocked until the register is zeroed.

// File: rtl/sticky_cap_pkg.sv
package sticky_cap_pkg;

    localparam int DEFAULT_WIDTH = 8;

    // Source chosen for the next stored value
    typedef enum logic [1:0] {
        SRC_KEEP     = 2'd0,
        SRC_CAPTURE  = 2'd1,
        SRC_SOFTWARE = 2'd2
    } upd_src_e;

    // Software writes win; capture only when empty and input nonzero
    function automatic upd_src_e pick_source(
        input logic sw_write,
        input logic store_empty,
        input logic input_nonzero
    );
        if (sw_write)
            return SRC_SOFTWARE;
        else if (store_empty && input_nonzero)
            return SRC_CAPTURE;
        else
            return SRC_KEEP;
    endfunction

endpackage

// File: rtl/sticky_cap_next.sv
module sticky_cap_next
    import sticky_cap_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] cur_value,
    input  logic [WIDTH-1:0] hw_value,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] nxt_value,
    output upd_src_e         src
);

    logic store_empty;
    logic input_nonzero;

    assign store_empty   = (cur_value == '0);
    assign input_nonzero = (hw_value != '0);

    always_comb begin
        src = pick_source(wr_en, store_empty, input_nonzero);
        unique case (src)
            SRC_SOFTWARE: nxt_value = wr_data;
            SRC_CAPTURE:  nxt_value = hw_value;
            default:      nxt_value = cur_value;
        endcase
    end

endmodule

// File: rtl/sticky_cap_store.sv
module sticky_cap_store
    import sticky_cap_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_src_e         src,
    input  logic [WIDTH-1:0] nxt_value,
    output logic [WIDTH-1:0] value_q
);

    always_ff @(posedge clk) begin
        if (rst)
            value_q <= '0;
        else if (src != SRC_KEEP)
            value_q <= nxt_value;
    end

endmodule

// File: rtl/sticky_cap_reg.sv
module sticky_cap_reg
    import sticky_cap_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hw_value,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] nxt_value;
    upd_src_e         src;

    sticky_cap_next #(.WIDTH(WIDTH)) u_next (
        .cur_value (value_q),
        .hw_value  (hw_value),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .nxt_value (nxt_value),
        .src       (src)
    );

    sticky_cap_store #(.WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .nxt_value (nxt_value),
        .value_q   (value_q)
    );

    assign rd_data = value_q;

endmodule

// File: rtl/sticky_cap_chk.sv
module sticky_cap_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] hw_value,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] rd_data
);

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_data == '0 && hw_value != '0) |=> rd_data == $past(hw_value));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_data != '0) |=> $stable(rd_data));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_data == '0 && hw_value == '0) |=> rd_data == '0);

    // R5, R6 and R7: a software write always lands as written
    a_r6_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == $past(wr_data));

endmodule

bind sticky_cap_reg sticky_cap_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hw_value (hw_value),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data)
);

// File: tb/test_sticky_cap_reg.sv
module test_sticky_cap_reg;

    localparam int W     = 8;
    localparam int NVEC  = 16;
    localparam int LIMIT = 5000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] hw_value = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sticky_cap_reg #(.WIDTH(W)) i_sticky_cap_reg (
        .clk      (clk),
        .rst      (rst),
        .hw_value (hw_value),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    // {req id, wr_en, wr_data, hw_value, expected read after the edge}
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd4, 1'b0, 8'h00, 8'h00, 8'h00},  // R4 idle stays zero
        {4'd2, 1'b0, 8'h00, 8'h12, 8'h12},  // R2 first nonzero captured
        {4'd3, 1'b0, 8'h00, 8'h34, 8'h12},  // R3 ignored
        {4'd3, 1'b0, 8'h00, 8'h56, 8'h12},  // R3 ignored
        {4'd6, 1'b1, 8'h00, 8'h56, 8'h00},  // R6 clear wins over input
        {4'd5, 1'b0, 8'h00, 8'h56, 8'h56},  // R5 same word recaptured
        {4'd5, 1'b1, 8'h00, 8'h00, 8'h00},  // R5 clear
        {4'd6, 1'b1, 8'h00, 8'h77, 8'h00},  // R6 zero write beats capture
        {4'd6, 1'b0, 8'h00, 8'h77, 8'h77},  // R6 capture resumes next cycle
        {4'd7, 1'b1, 8'hA5, 8'h00, 8'hA5},  // R7 software load
        {4'd7, 1'b0, 8'h00, 8'h3C, 8'hA5},  // R7 capture blocked
        {4'd5, 1'b1, 8'h00, 8'h00, 8'h00},  // R5 clear re-arms
        {4'd2, 1'b0, 8'h00, 8'h80, 8'h80},  // R2 top bit only
        {4'd5, 1'b1, 8'h00, 8'h00, 8'h00},  // R5 clear
        {4'd2, 1'b0, 8'h00, 8'h01, 8'h01},  // R2 bottom bit only
        {4'd3, 1'b0, 8'h00, 8'hFF, 8'h01}   // R3 all-ones ignored
    };

    task automatic check(input int req, input logic [W-1:0] exp, input string what);
        n_vec++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: rd_data=%02h expected=%02h", req, what, rd_data, exp);
        end
    endtask

    task automatic step(input logic we, input logic [W-1:0] wd, input logic [W-1:0] hv);
        @(negedge clk);
        wr_en    = we;
        wr_data  = wd;
        hw_value = hv;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(LIMIT * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a nonzero input present
        hw_value = 8'h5A;
        repeat (3) @(posedge clk);
        #1;
        check(1, 8'h00, "held in reset with input nonzero");
        @(negedge clk);
        rst      = 1'b0;
        hw_value = 8'h00;
        @(posedge clk);
        #1;
        check(1, 8'h00, "first cycle after reset");

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            check(int'(VEC[i][28:25]), VEC[i][7:0], $sformatf("vector %0d", i));
        end

        // R1: reset clears a held value
        step(1'b0, 8'h00, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1, 8'h00, "reset clears held value");
        // R2: after reset is released, a pending input is captured
        @(negedge clk);
        rst      = 1'b0;
        hw_value = 8'hC3;
        @(posedge clk);
        #1;
        check(2, 8'hC3, "capture right after reset");
        // R7: nonzero write over a held value, then held against input
        step(1'b1, 8'h42, 8'h99);
        check(7, 8'h42, "write replaces held value");
        step(1'b0, 8'h00, 8'h99);
        check(7, 8'h42, "written value blocks capture");
        // R5: long run of input after a clear keeps the first word
        step(1'b1, 8'h00, 8'h10);
        check(5, 8'h00, "clear with input present");
        step(1'b0, 8'h00, 8'h10);
        check(5, 8'h10, "recapture after clear");
        step(1'b0, 8'h00, 8'h20);
        check(3, 8'h10, "later word ignored");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule